// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands one multiplier bit per clock cycle. It uses a single adder as wide as an operand and one product register twice that width. A one-cycle start pulse captures the multiplicand into a holding register. The same pulse places the multiplier in the low half of the product register and clears the high half.

In each of the following WIDTH cycles the block tests the lowest bit of the product register. When that bit is 1 it adds the multiplicand into the high half. It then shifts the whole register right by one place, and the adder's carry-out enters at the top. The multiplier has no register of its own: the shift consumes it bit by bit from the low half while the partial sums grow in the high half.

When the last iteration ends, the block drops busy and pulses done. The high and low words of the product stay on their outputs until the next start. Software tests the high word against zero to find out whether the product fits in a single word.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is held and on the first cycle after it, busy and done are 0 and both product words are 0.
- R2: A start pulse sampled while busy is 0 raises busy on the next cycle; at that point the high word is 0 and the low word holds the multiplier.
- R3: After the start cycle, busy stays 1 for exactly WIDTH cycles; done rises on the same cycle that busy falls.
- R4: Done is 1 for exactly one cycle per accepted start and is never 1 together with busy.
- R5: When done is 1, {hi, lo} equals the unsigned 2*WIDTH-bit product of the multiplicand and multiplier that were sampled with the accepted start.
- R6: A start pulse, or a change on the operand inputs, while busy is 1 has no effect on the result or on the timing of done.
- R7: The adder's carry-out is kept at every step, so operands with all bits 1 give the exact product 2^(2*WIDTH) - 2^(WIDTH+1) + 1.
- R8: Once done has pulsed, hi and lo stay unchanged until the next accepted start.
- R9: The high word is 0 exactly when the product is below 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin a multiplication |
| mcand_i | input | WIDTH | Multiplicand, sampled with an accepted start |
| mplr_i | input | WIDTH | Multiplier, sampled with an accepted start |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| hi_o | output | WIDTH | Upper word of the product register |
| lo_o | output | WIDTH | Lower word of the product register |

## Verification
The assertions assume a reset that is synchronous and held for at least one clock edge. They also assume that start and the operand inputs are stable around the rising edge. Operands need to be valid only in the cycle in which start is accepted.

The stimulus changes every input half a period away from the rising edge. It reads the outputs at the same half-period point. A start is raised for one cycle only, except in the deliberate test in which start and fresh operands are driven in the middle of a run.

A 4-bit instance is swept over all operand pairs. The 32-bit instance is run on zero, one, all-ones and random operand values.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

    typedef enum logic {
        MUL_IDLE = 1'b0,
        MUL_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic load;   // capture operands, clear high half
        logic step;   // one add-and-shift iteration
    } mul_ctl_t;

    function automatic mul_ctl_t mul_decode(mul_state_e st, logic start);
        mul_ctl_t c;
        c.load = (st == MUL_IDLE) && start;
        c.step = (st == MUL_RUN);
        return c;
    endfunction

endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output mul_ctl_t ctl_o,
    output logic     busy_o,
    output logic     done_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    mul_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    mul_ctl_t      ctl;

    assign ctl    = mul_decode(state_q, start_i);
    assign ctl_o  = ctl;
    assign busy_o = (state_q == MUL_RUN);
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MUL_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                MUL_IDLE: begin
                    if (ctl.load) begin
                        state_q <= MUL_RUN;
                        cnt_q   <= '0;
                    end
                end
                MUL_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= MUL_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= MUL_IDLE;
            endcase
        end
    end

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && cnt_q == '0));

    assert_run_continues_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q != LAST) |=> busy_o);

    assert_run_ends_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q == LAST) |=> (done_o && !busy_o));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  mul_ctl_t         ctl_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplr_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int SW = WIDTH + 1;

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [SW-1:0]    addend;
    logic [SW-1:0]    sum;

    // Add the multiplicand into the high half when the tested bit is set;
    // the extra bit keeps the carry for the following shift.
    assign addend = lo_q[0] ? {1'b0, mcand_q} : '0;
    assign sum    = {1'b0, hi_q} + addend;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (ctl_i.load) begin
            mcand_q <= mcand_i;
            hi_q    <= '0;
            lo_q    <= mplr_i;
        end else if (ctl_i.step) begin
            hi_q <= sum[SW-1:1];
            lo_q <= {sum[0], lo_q[WIDTH-1:1]};
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    assert_load_contents_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> (hi_q == '0 && lo_q == $past(mplr_i) && mcand_q == $past(mcand_i)));

    assert_mcand_kept_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl_i.load |=> $stable(mcand_q));

    assert_product_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.load && !ctl_i.step) |=> ($stable(hi_q) && $stable(lo_q)));

    assert_no_dual_ctl_R6: assert property (@(posedge clk) disable iff (rst)
        !(ctl_i.load && ctl_i.step));

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplr_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    mul_ctl_t ctl;

    shiftadd_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    shiftadd_mul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .mcand_i (mcand_i),
        .mplr_i  (mplr_i),
        .hi_o    (hi_o),
        .lo_o    (lo_o)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && hi_o == '0 && lo_o == '0));

endmodule

// File: tb/sim_shiftadd_mul.sv
`timescale 1ns/1ps
module sim_shiftadd_mul;
    localparam int W  = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic          start = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic          busy, done;
    logic [W-1:0]  hi, lo;

    logic          s_start = 1'b0;
    logic [SW-1:0] sa = '0, sb = '0;
    logic          s_busy, s_done;
    logic [SW-1:0] s_hi, s_lo;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    shiftadd_mul #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .mcand_i(a), .mplr_i(b),
        .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
    );

    shiftadd_mul #(.WIDTH(SW)) u1 (
        .clk(clk), .rst(rst), .start_i(s_start), .mcand_i(sa), .mplr_i(sb),
        .busy_o(s_busy), .done_o(s_done), .hi_o(s_hi), .lo_o(s_lo)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full 32-bit run: start, optional interference mid-run, result checks.
    task automatic run_big(input logic [W-1:0] x, input logic [W-1:0] y, input bit disturb);
        logic [63:0] exp;
        exp = {32'b0, x} * {32'b0, y};
        @(negedge clk);
        start = 1'b1; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && hi === '0 && lo === y, "R2", {hi, lo}, {32'b0, y});
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            if (disturb && i == 5) begin
                start = 1'b1; a = ~x; b = ~y;
            end else if (disturb && i == 6) begin
                start = 1'b0;
            end
            if (i == W - 1)
                check(busy === 1'b1 && done === 1'b0, "R3", {62'b0, busy, done}, 64'h2);
        end
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b1, "R3", {62'b0, busy, done}, 64'h1);
        check({hi, lo} === exp, disturb ? "R6" : "R5", {hi, lo}, exp);
        check((hi == '0) == (exp < 64'h1_0000_0000), "R9", {32'b0, hi}, exp >> 32);
        @(negedge clk);
        check(done === 1'b0, "R4", {63'b0, done}, 64'h0);
        @(negedge clk);
        check({hi, lo} === exp && busy === 1'b0, "R8", {hi, lo}, exp);
    endtask

    task automatic run_small(input logic [SW-1:0] x, input logic [SW-1:0] y);
        logic [7:0] exp;
        exp = {4'b0, x} * {4'b0, y};
        @(negedge clk);
        s_start = 1'b1; sa = x; sb = y;
        @(negedge clk);
        s_start = 1'b0;
        for (int i = 1; i < SW; i++) @(negedge clk);
        check(s_busy === 1'b1 && s_done === 1'b0, "R3", {62'b0, s_busy, s_done}, 64'h2);
        @(negedge clk);
        check(s_done === 1'b1 && {s_hi, s_lo} === exp, "R5", {56'b0, s_hi, s_lo}, {56'b0, exp});
        check((s_hi == '0) == (exp < 8'd16), "R9", {60'b0, s_hi}, {60'b0, exp[7:4]});
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && hi === '0 && lo === '0, "R1", {hi, lo}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && hi === '0 && lo === '0, "R1", {hi, lo}, 64'h0);

        run_big(32'h0, 32'h1234_5678, 1'b0);
        run_big(32'hDEAD_BEEF, 32'h0, 1'b0);
        run_big(32'h1, 32'hCAFE_F00D, 1'b0);
        run_big(32'h8765_4321, 32'h1, 1'b0);
        run_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R7 all-ones carry case
        check({hi, lo} === 64'hFFFF_FFFE_0000_0001, "R7", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
        run_big(32'hFFFF_FFFF, 32'h1, 1'b0);
        run_big(32'h0001_0000, 32'h0000_FFFF, 1'b0);
        run_big(32'hA5A5_1234, 32'h5A5A_9876, 1'b1);  // R6 interference mid-run
        for (int k = 0; k < 30; k++)
            run_big($urandom, $urandom, 1'b0);

        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                run_small(SW'(x), SW'(y));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule